// File: doc/BRIEF.md
# Quad Enable Bit Sequencer

This block runs the serial-flash command sequence that turns on the device's quad-enable bit. A 3-bit requirement code, taken from the flash's discovered parameters, selects how the bit is handled: which register holds it, the opcode that reads that register, the write opcode, the number of data bytes written, and the bit position. A one-cycle `start` launches a run. The block reads the register that holds the bit. If the bit is already set, it stops. If not, it keeps the neighbouring status bytes, issues write enable, writes the register, polls the busy flag up to a programmable limit, and reads the register back to confirm the bit stuck. The run ends with a one-cycle `done` and a held `ok` or `err`.

Bytes move to and from a byte-level SPI master over two valid/ready channels. Every byte sent on the transmit channel yields exactly one reply byte on the receive channel, and the sequencer waits for that reply before it offers the next byte. `tx_last` marks the final byte of a frame, where the master releases chip select. Once `tx_valid` is high it stays high, with `tx_data` and `tx_last` unchanged, until `tx_ready` accepts the byte. `rx_ready` is high only while the sequencer waits for a reply. Reads are sent as the opcode followed by one dummy byte 0x00, and the reply to the dummy byte is the register value.

Top module: `qe_sequencer`

## Requirements
- R1: Code 000 (no quad-enable bit) ends the run with `done` and `ok` in the cycle after `start`, and no byte is sent.
- R2: Codes 110 and 111 are unsupported. They end the run with `done` and `err` in the cycle after `start`, and no byte is sent.
- R3: The first frame reads the register holding the bit as [opcode, 0x00]. The opcode is 0x05 for code 010, 0x3F for code 011, and 0x35 for codes 001, 100 and 101.
- R4: If the value read already has the enable bit set, the run ends with `ok` and no write enable or write is sent.
- R5: Every register write is preceded by a single-byte write-enable frame 0x06.
- R6: Code 010 writes [0x01, value | 0x40] (status register 1, bit 6). Code 011 writes [0x3E, value | 0x80] (status register 2, bit 7).
- R7: Codes 001, 100 and 101 first read status register 1 with [0x05, 0x00]. They then write the three-byte frame [0x01, status1, value | 0x02], with the bit at position 1 of the second data byte. A two-byte 0x01 write is never used for these codes.
- R8: After the write, frames [0x05, 0x00] are repeated until bit 0 of the reply is 0. When the number of busy replies reaches `poll_limit` (a limit of 0 counts as 1), the run ends with `err`.
- R9: Once the device is ready, the register is read again with the R3 opcode. The run ends with `ok` if the enable bit is set and with `err` if it is clear.
- R10: Transmit channel: `tx_valid` is held, with `tx_data` and `tx_last` stable, until `tx_ready` accepts the byte. Each accepted byte is answered by one receive handshake before the next byte is offered.
- R11: `done` is a single-cycle pulse. Exactly one of `ok` and `err` is set with it, and both are held until the next accepted `start`. A `start` that arrives during a run is ignored.
- R12: During reset, `done`, `ok`, `err`, `tx_valid` and `rx_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, accepted only while idle |
| qer_code | input | 3 | Quad-enable requirement code |
| poll_limit | input | POLL_W | Maximum number of busy replies tolerated |
| tx_valid | output | 1 | Transmit byte offered |
| tx_ready | input | 1 | Master accepts the transmit byte |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Last byte of the frame |
| rx_valid | input | 1 | Reply byte available |
| rx_ready | output | 1 | Sequencer waits for a reply |
| rx_data | input | 8 | Reply byte |
| done | output | 1 | Run finished (one cycle) |
| ok | output | 1 | Run succeeded, held |
| err | output | 1 | Run failed, held |

## Verification
The bench drives a behavioural flash that answers reads, applies writes only after write enable, clears status register 2 on a two-byte 0x01 write, and can hold its busy flag or ignore writes. The corner cases it targets are these: the bit already set (a broken design would issue a needless write), the bit-1 codes (a design that wrote too few bytes would wipe status register 2), and a busy count exactly at the limit or with a zero limit (an off-by-one design would either hang on to success or fail one poll early). A write that does not take is also covered; a design that skipped the read-back would report success. Transmit back-pressure stalls and a `start` during a run check that the stream and launch rules hold.

// File: rtl/qe_pkg.sv
package qe_pkg;

  localparam logic [7:0] OP_RD_SR1  = 8'h05;
  localparam logic [7:0] OP_RD_CFG  = 8'h35;
  localparam logic [7:0] OP_RD_SR2H = 8'h3F;
  localparam logic [7:0] OP_WR_SR   = 8'h01;
  localparam logic [7:0] OP_WR_SR2H = 8'h3E;
  localparam logic [7:0] OP_WEN     = 8'h06;
  localparam logic [7:0] DUMMY_BYTE = 8'h00;

  typedef struct packed {
    logic       none;      // no enable bit at all
    logic       bad;       // unsupported code
    logic       use_bit1;  // three-byte write keeping status register 1
    logic [7:0] rd_op;
    logic [7:0] wr_op;
    logic [2:0] bitpos;
  } plan_t;

  function automatic plan_t decode_code(input logic [2:0] code);
    plan_t p;
    p.none     = 1'b0;
    p.bad      = 1'b0;
    p.use_bit1 = 1'b0;
    p.rd_op    = OP_RD_SR1;
    p.wr_op    = OP_WR_SR;
    p.bitpos   = 3'd0;
    case (code)
      3'b000: p.none = 1'b1;
      3'b010: p.bitpos = 3'd6;
      3'b011: begin
        p.rd_op  = OP_RD_SR2H;
        p.wr_op  = OP_WR_SR2H;
        p.bitpos = 3'd7;
      end
      3'b001, 3'b100, 3'b101: begin
        p.rd_op    = OP_RD_CFG;
        p.bitpos   = 3'd1;
        p.use_bit1 = 1'b1;
      end
      default: p.bad = 1'b1;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/qe_plan.sv
module qe_plan
  import qe_pkg::*;
(
  input  logic [2:0] code,
  output plan_t      plan
);
  always_comb plan = decode_code(code);
endmodule

// File: rtl/qe_byte_xfer.sv
module qe_byte_xfer #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [BW-1:0] byte_in,
  input  logic          last_in,
  output logic          idle,
  output logic          ack,
  output logic [BW-1:0] rx_byte,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [BW-1:0] tx_data,
  output logic          tx_last,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [BW-1:0] rx_data
);
  typedef enum logic [1:0] {E_IDLE, E_SEND, E_WAIT} est_t;
  est_t          est;
  logic [BW-1:0] byte_q;
  logic          last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      est    <= E_IDLE;
      byte_q <= '0;
      last_q <= 1'b0;
    end else begin
      case (est)
        E_IDLE: if (go) begin
          byte_q <= byte_in;
          last_q <= last_in;
          est    <= E_SEND;
        end
        E_SEND: if (tx_ready) est <= E_WAIT;
        E_WAIT: if (rx_valid) est <= E_IDLE;
        default: est <= E_IDLE;
      endcase
    end
  end

  assign idle     = (est == E_IDLE);
  assign tx_valid = (est == E_SEND);
  assign tx_data  = byte_q;
  assign tx_last  = last_q;
  assign rx_ready = (est == E_WAIT);
  assign ack      = rx_valid && rx_ready;
  assign rx_byte  = rx_data;

  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R10
  go_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> idle);

  // R10
  one_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (rx_ready && !tx_valid));
endmodule

// File: rtl/qe_poll_cnt.sv
module qe_poll_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         bump,
  input  logic [W-1:0] limit,
  output logic         last_chance
);
  localparam int CW = W + 1;
  logic [W-1:0]  cnt;
  logic [CW-1:0] eff_limit;
  logic [CW-1:0] next_cnt;

  always_comb begin
    eff_limit   = (limit == '0) ? CW'(1) : {1'b0, limit};
    next_cnt    = {1'b0, cnt} + CW'(1);
    last_chance = (next_cnt >= eff_limit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (bump)  cnt <= cnt + W'(1);
  end

  // R8
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bump |-> !last_chance);
endmodule

// File: rtl/qe_sequencer.sv
module qe_sequencer
  import qe_pkg::*;
#(
  parameter int POLL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        qer_code,
  input  logic [POLL_W-1:0] poll_limit,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  output logic              done,
  output logic              ok,
  output logic              err
);
  typedef enum logic [2:0] {
    S_IDLE, S_RDQE, S_RDSR1, S_WREN, S_WRITE, S_POLL, S_VERIFY
  } st_t;

  st_t        st;
  logic [2:0] code_q;
  logic [1:0] idx;
  logic [7:0] cur_q;
  logic [7:0] sr1_q;

  plan_t      plan;
  logic [2:0] plan_code;
  logic [7:0] mask;
  logic [7:0] fb_byte;
  logic       fb_last;
  logic       go, eng_idle, ack;
  logic [7:0] rx_byte;
  logic       frame_end, qe_hit, poll_bump, poll_last;

  assign plan_code = (st == S_IDLE) ? qer_code : code_q;

  qe_plan u_plan (.code(plan_code), .plan(plan));

  assign mask = 8'd1 << plan.bitpos;

  // Frame builder: byte and last flag for (state, index)
  always_comb begin
    fb_byte = DUMMY_BYTE;
    fb_last = 1'b0;
    case (st)
      S_RDQE, S_VERIFY: begin
        fb_byte = (idx == 2'd0) ? plan.rd_op : DUMMY_BYTE;
        fb_last = (idx != 2'd0);
      end
      S_RDSR1, S_POLL: begin
        fb_byte = (idx == 2'd0) ? OP_RD_SR1 : DUMMY_BYTE;
        fb_last = (idx != 2'd0);
      end
      S_WREN: begin
        fb_byte = OP_WEN;
        fb_last = 1'b1;
      end
      S_WRITE: begin
        if (idx == 2'd0) begin
          fb_byte = plan.wr_op;
        end else if (plan.use_bit1 && idx == 2'd1) begin
          fb_byte = sr1_q;
        end else begin
          fb_byte = cur_q | mask;
          fb_last = 1'b1;
        end
      end
      default: ;
    endcase
  end

  assign go = (st != S_IDLE) && eng_idle;

  qe_byte_xfer #(.BW(8)) u_xfer (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .byte_in  (fb_byte),
    .last_in  (fb_last),
    .idle     (eng_idle),
    .ack      (ack),
    .rx_byte  (rx_byte),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .tx_last  (tx_last),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_data  (rx_data)
  );

  assign frame_end = ack && fb_last;
  assign qe_hit    = rx_byte[plan.bitpos];
  assign poll_bump = (st == S_POLL) && frame_end && rx_byte[0] && !poll_last;

  qe_poll_cnt #(.W(POLL_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (st == S_WRITE),
    .bump        (poll_bump),
    .limit       (poll_limit),
    .last_chance (poll_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      code_q <= '0;
      idx    <= '0;
      cur_q  <= '0;
      sr1_q  <= '0;
      done   <= 1'b0;
      ok     <= 1'b0;
      err    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        if (start) begin
          ok     <= 1'b0;
          err    <= 1'b0;
          code_q <= qer_code;
          idx    <= '0;
          if (plan.none) begin
            done <= 1'b1;
            ok   <= 1'b1;
          end else if (plan.bad) begin
            done <= 1'b1;
            err  <= 1'b1;
          end else begin
            st <= S_RDQE;
          end
        end
      end else if (ack) begin
        if (!fb_last) begin
          idx <= idx + 2'd1;
        end else begin
          idx <= '0;
          case (st)
            S_RDQE: begin
              cur_q <= rx_byte;
              if (qe_hit) begin
                st   <= S_IDLE;
                done <= 1'b1;
                ok   <= 1'b1;
              end else if (plan.use_bit1) begin
                st <= S_RDSR1;
              end else begin
                st <= S_WREN;
              end
            end
            S_RDSR1: begin
              sr1_q <= rx_byte;
              st    <= S_WREN;
            end
            S_WREN:  st <= S_WRITE;
            S_WRITE: st <= S_POLL;
            S_POLL: begin
              if (!rx_byte[0]) begin
                st <= S_VERIFY;
              end else if (poll_last) begin
                st   <= S_IDLE;
                done <= 1'b1;
                err  <= 1'b1;
              end
            end
            S_VERIFY: begin
              st   <= S_IDLE;
              done <= 1'b1;
              ok   <= qe_hit;
              err  <= !qe_hit;
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

  // R1
  none_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && qer_code == 3'b000) |=> (done && ok && !tx_valid));

  // R2
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && qer_code[2:1] == 2'b11) |=> (done && err && !tx_valid));

  // R4
  early_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RDQE && frame_end && qe_hit) |=> (done && ok));

  // R5
  wren_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == S_WRITE) |-> ($past(st) == S_WREN));

  // R7
  three_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WRITE && plan.use_bit1 && tx_valid && tx_ready && idx == 2'd1) |-> !tx_last);

  // R8
  poll_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_POLL && frame_end && rx_byte[0] && poll_last) |=> (done && err));

  // R9
  verify_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_VERIFY && frame_end && !qe_hit) |=> (done && err));

  // R11
  result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ok ^ err));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/sim_qe_sequencer.sv
module sim_qe_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  qer_code = 3'b000;
  logic [15:0] poll_limit = 16'd8;
  logic        tx_valid, tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        tx_last;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  rx_data = 8'h00;
  logic        done, ok, err;

  always #10 clk = ~clk;

  qe_sequencer #(.POLL_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .qer_code(qer_code),
    .poll_limit(poll_limit), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .done(done), .ok(ok), .err(err)
  );

  int errors = 0;
  int checks = 0;

  // flash model state
  logic [7:0] m_sr1, m_sr2;
  int         m_busy_n, m_busy_left;
  logic       m_wel, m_stick;
  int         m_stall;
  logic [7:0] fbuf [4];
  int         fi = 0;
  logic [7:0] first_op;
  int         nframes, nwrites, nwren, viol, wlen, stall_bad;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply_frame();
    logic [7:0] op;
    op = fbuf[0];
    if (nframes == 0) first_op = op;
    nframes++;
    if (op == 8'h06) begin
      m_wel = 1'b1;
      nwren++;
    end else if ((op == 8'h01 || op == 8'h3E) && fi >= 2) begin
      nwrites++;
      wlen = fi;
      if (!m_wel) viol++;
      if (!m_stick) begin
        if (op == 8'h01) begin
          m_sr1 = fbuf[1];
          m_sr2 = (fi == 3) ? fbuf[2] : 8'h00;
        end else begin
          m_sr2 = fbuf[1];
        end
      end
      m_wel = 1'b0;
      m_busy_left = m_busy_n;
    end
  endtask

  initial begin
    logic [7:0] b, reply;
    logic       l;
    forever begin
      @(negedge clk);
      if (tx_valid && rst_n) begin
        b = tx_data;
        l = tx_last;
        for (int s = 0; s < m_stall; s++) begin
          @(negedge clk);
          if (!tx_valid || tx_data != b || tx_last != l) stall_bad++;
        end
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        if (fi < 4) fbuf[fi] = b;
        reply = 8'hFF;
        if (fi >= 1) begin
          if (fbuf[0] == 8'h05) begin
            reply = m_sr1 | ((m_busy_left > 0) ? 8'h01 : 8'h00);
            if (m_busy_left > 0) m_busy_left--;
          end else if (fbuf[0] == 8'h35 || fbuf[0] == 8'h3F) begin
            reply = m_sr2;
          end
        end
        fi++;
        rx_valid = 1'b1;
        rx_data  = reply;
        @(negedge clk);
        rx_valid = 1'b0;
        if (l) begin
          apply_frame();
          fi = 0;
        end
      end
    end
  end

  task automatic set_model(input logic [7:0] s1, input logic [7:0] s2,
                           input int busy, input logic stick, input int stall);
    m_sr1 = s1; m_sr2 = s2; m_busy_n = busy; m_busy_left = 0;
    m_wel = 1'b0; m_stick = stick; m_stall = stall;
    first_op = 8'h00; nframes = 0; nwrites = 0; nwren = 0; viol = 0; wlen = 0;
    fi = 0;
  endtask

  // returns 1 if done seen
  task automatic run(input logic [2:0] c, output logic got);
    int n;
    @(negedge clk);
    qer_code = c;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got = done;
    n = 0;
    while (!got && n < 3000) begin
      @(negedge clk);
      got = done;
      n++;
    end
    if (!got) begin
      errors++;
      checks++;
      $display("FAIL watchdog R11 actual=no_done expected=done");
    end
  endtask

  typedef struct packed {
    logic [2:0] code;
    logic [7:0] sr1;
    logic [7:0] sr2;
    logic [3:0] busy;
    logic [7:0] lim;
    logic       stick;
    logic       stall;
    logic       eok;
    logic [7:0] rdop;
    logic [3:0] wlen;
    logic [7:0] f1;
    logic [7:0] f2;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    '{3'b000, 8'h00, 8'h00, 4'd0, 8'd8, 1'b0, 1'b0, 1'b1, 8'h00, 4'd0, 8'h00, 8'h00},
    '{3'b010, 8'h0C, 8'h11, 4'd2, 8'd8, 1'b0, 1'b0, 1'b1, 8'h05, 4'd2, 8'h4C, 8'h00},
    '{3'b010, 8'h40, 8'h11, 4'd0, 8'd8, 1'b0, 1'b0, 1'b1, 8'h05, 4'd0, 8'h40, 8'h11},
    '{3'b011, 8'h20, 8'h05, 4'd1, 8'd8, 1'b0, 1'b1, 1'b1, 8'h3F, 4'd2, 8'h20, 8'h85},
    '{3'b011, 8'h00, 8'h80, 4'd0, 8'd8, 1'b0, 1'b0, 1'b1, 8'h3F, 4'd0, 8'h00, 8'h80},
    '{3'b001, 8'h1C, 8'h30, 4'd3, 8'd4, 1'b0, 1'b1, 1'b1, 8'h35, 4'd3, 8'h1C, 8'h32},
    '{3'b100, 8'h04, 8'h02, 4'd0, 8'd8, 1'b0, 1'b0, 1'b1, 8'h35, 4'd0, 8'h04, 8'h02},
    '{3'b101, 8'h3C, 8'h00, 4'd0, 8'd8, 1'b0, 1'b0, 1'b1, 8'h35, 4'd3, 8'h3C, 8'h02},
    '{3'b101, 8'h08, 8'h40, 4'd4, 8'd4, 1'b0, 1'b0, 1'b0, 8'h35, 4'd3, 8'h08, 8'h42},
    '{3'b011, 8'h20, 8'h00, 4'd0, 8'd8, 1'b1, 1'b0, 1'b0, 8'h3F, 4'd2, 8'h20, 8'h00},
    '{3'b110, 8'h00, 8'h00, 4'd0, 8'd8, 1'b0, 1'b0, 1'b0, 8'h00, 4'd0, 8'h00, 8'h00},
    '{3'b111, 8'h00, 8'h00, 4'd0, 8'd8, 1'b0, 1'b0, 1'b0, 8'h00, 4'd0, 8'h00, 8'h00},
    '{3'b010, 8'h00, 8'h00, 4'd1, 8'd0, 1'b0, 1'b0, 1'b0, 8'h05, 4'd2, 8'h40, 8'h00},
    '{3'b001, 8'h00, 8'h00, 4'd0, 8'd0, 1'b0, 1'b1, 1'b1, 8'h35, 4'd3, 8'h00, 8'h02}
  };

  function automatic string tag_for(input vec_t v);
    int eff;
    eff = (v.lim == 0) ? 1 : int'(v.lim);
    if (v.code == 3'b000) return "R1";
    if (v.code[2:1] == 2'b11) return "R2";
    if (v.stick) return "R9";
    if (v.wlen != 0 && int'(v.busy) >= eff) return "R8";
    if (v.wlen == 0) return "R4";
    if (v.code == 3'b010 || v.code == 3'b011) return "R6";
    return "R7";
  endfunction

  initial begin
    logic got;
    stall_bad = 0;
    set_model(8'h00, 8'h00, 0, 1'b0, 0);
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 done", done, 0);
    check("R12 ok_err", {ok, err}, 0);
    check("R12 tx_valid", tx_valid, 0);
    check("R12 rx_ready", rx_ready, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string t;
      vec_t v;
      v = VT[i];
      t = tag_for(v);
      set_model(v.sr1, v.sr2, int'(v.busy), v.stick, v.stall ? 2 : 0);
      poll_limit = {8'h00, v.lim};
      run(v.code, got);
      check($sformatf("%s ok vec%0d", t, i), ok, v.eok);
      check($sformatf("%s err vec%0d", t, i), err, !v.eok);
      repeat (3) @(negedge clk);
      check($sformatf("R3 read opcode vec%0d", i), first_op, v.rdop);
      check($sformatf("%s write length vec%0d", t, i), wlen, v.wlen);
      check($sformatf("%s status1 vec%0d", t, i), m_sr1, v.f1);
      check($sformatf("%s status2 vec%0d", t, i), m_sr2, v.f2);
      check($sformatf("R5 wren before write vec%0d", i), viol, 0);
      check($sformatf("R5 wren count vec%0d", i), nwren, nwrites);
    end

    // R1 timing: done one cycle after start, nothing sent
    set_model(8'h00, 8'h00, 0, 1'b0, 0);
    @(negedge clk);
    qer_code = 3'b000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R1 done next cycle", {done, ok, err}, 3'b110);
    // R11 pulse width and hold
    @(negedge clk);
    check("R11 done pulse", done, 0);
    check("R11 ok held", {ok, err}, 2'b10);
    check("R1 no frames", nframes, 0);

    // R2 timing
    @(negedge clk);
    qer_code = 3'b111;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 done next cycle", {done, ok, err}, 3'b101);

    // R11 start during a run is ignored
    set_model(8'h20, 8'h05, 1, 1'b0, 0);
    poll_limit = 16'd8;
    @(negedge clk);
    qer_code = 3'b011;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    qer_code = 3'b110;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got = done;
    for (int n = 0; n < 3000 && !got; n++) begin
      @(negedge clk);
      got = done;
    end
    check("R11 run completes", got, 1);
    check("R11 busy start ignored", {ok, err}, 2'b10);
    repeat (3) @(negedge clk);
    check("R11 status2 after run", m_sr2, 8'h85);

    // R10 back-pressure kept data stable
    check("R10 stable under stall", stall_bad, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule